// File: doc/BRIEF.md
# Output Channel Character Disassembler

This block is the output half of one I/O channel. It holds a 24-bit word and hands it to an attached device one character at a time, most significant character first. A character is 6, 12 or 24 bits wide. A word reaches the block in one of two ways. Under interlace, the block reads the word from memory at a running address and keeps a word count. Without interlace, the program writes the word directly into the channel buffer.

Each time the device strobes a request, it receives exactly one character. When the buffer empties, the block chooses what to do from the terminal function chosen at connect time. The choices are:
- raise an end-of-word, zero-word-count, end-of-transmission or end-of-record interrupt;
- ask the device to write an end of record;
- disconnect.

A terminate command that arrives while data is still in flight is held until the buffer drains. A device that cannot accept data yet can leave a wake-up request, and the next program buffer load honours it.

Top module: `chan_out_disasm`

## Requirements
- R1: After reset the channel is disconnected, the error and inter-record flags are clear, and every pulse output (charValid, wreor, asyncGrant, irqEow, irqZwc, irqEot, irqEor) is low.
- R2: connStart connects the channel and latches the width, characters-per-word, function and interrupt enables. If connIlc is 0 and intEnable is 1, irqEow pulses on the following cycle. If connIlc is 1, no irqEow pulses.
- R3: When the device requests a character with an empty buffer and interlace active, the block reads memory at the current address. It then advances the address by one, lowers the word count by one modulo 2^15, and loads the buffer with characters-per-word plus one characters. The first character of that word is delivered in the same request.
- R4: connWidth 0 selects 6-bit characters, taken from bits 23:18 with a 6-bit left shift per character. Code 1 selects 12-bit characters, taken from bits 23:12 with a 12-bit shift, and uses only bit 0 of connCpw. Codes 2 and 3 select 24-bit characters, one per word. connCpw gives characters-per-word minus one. charData is right-justified.
- R5: A request with an empty buffer and interlace off delivers no character and sets errFlag. A request that arrives in the cycle when a pending end of record is being handled is dropped and sets no error.
- R6: Compatible function (connFunc[2]=0): when interlace is on and the last character of the last word leaves the buffer, interlace stops, irqEot pulses if intEnable is 1, and the channel disconnects.
- R7: Extended functions (connFunc[2]=1, bit 1 means signal, bit 0 means proceed): at zero word count, irqZwc pulses if connZcEn is 1. Function 3'b110 also pulses irqEor if connErEn is 1 and disconnects. Functions with bit 1 clear, or a pending terminate, pulse wreor. The pending terminate is then cleared.
- R8: When the buffer empties with interlace off, a pending terminate is cleared and wreor pulses. Otherwise irqEow pulses if intEnable is 1.
- R9: termCmd on a connected channel whose buffer holds data or whose interlace is active becomes pending and pulses nothing. On an idle channel it pulses wreor on the next cycle.
- R10: bufWrite is accepted only when the buffer is empty, and it fills the buffer with characters-per-word plus one characters. A bufWrite to a non-empty buffer is ignored.
- R11: devAsync pulses asyncGrant if data is buffered or interlace is active. Otherwise it sets a wake flag. An accepted bufWrite while the wake flag is set pulses asyncGrant and clears the flag.
- R12: devEor flags end of record, and the block handles it on the next cycle. Handling stops interlace. It pulses irqEot in compatible mode when intEnable is 1, or irqEor in extended mode when connErEn is 1. It then sets interRec and stays connected for proceed functions (3'b101, 3'b111), or disconnects otherwise.
- R13: devErr on a connected channel sets errFlag. errFlag stays set until the next connStart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intEnable | input | 1 | Processor interrupts enabled |
| connStart | input | 1 | Connect pulse |
| connIlc | input | 1 | Connect expects an interlace load |
| connWidth | input | 2 | Character width code |
| connCpw | input | 2 | Characters per word minus one |
| connFunc | input | 3 | Terminal function {extended, signal, proceed} |
| connZcEn | input | 1 | Zero-word-count interrupt enable |
| connErEn | input | 1 | End-of-record interrupt enable |
| ilcLoad | input | 1 | Load interlace address and count, start interlace |
| ilcAddr | input | ADDR_W | Interlace start address |
| ilcCount | input | WC_W | Interlace word count |
| bufWrite | input | 1 | Program buffer write |
| bufData | input | WORD_W | Program buffer word |
| termCmd | input | 1 | Terminate-output command |
| devReq | input | 1 | Device requests one character |
| devAsync | input | 1 | Asynchronous device asks for output |
| devErr | input | 1 | Device write error |
| devEor | input | 1 | Device reports end of record |
| memRd | output | 1 | Memory read strobe, same cycle |
| memAddr | output | ADDR_W | Memory read address |
| memData | input | WORD_W | Memory read data, same cycle |
| charValid | output | 1 | Character delivered |
| charData | output | WORD_W | Character, right-justified |
| wreor | output | 1 | Write-end-of-record pulse to device |
| asyncGrant | output | 1 | Transfer request to an asynchronous device |
| irqEow | output | 1 | End-of-word interrupt pulse |
| irqZwc | output | 1 | Zero-word-count interrupt pulse |
| irqEot | output | 1 | End-of-transmission interrupt pulse |
| irqEor | output | 1 | End-of-record interrupt pulse |
| connected | output | 1 | Channel connected |
| errFlag | output | 1 | Rate or device error |
| interRec | output | 1 | Channel is between records |

## Verification
A request, terminate, async request, buffer load or connect sampled at one rising edge produces its character, wreor, grant, interrupt or status change right after that same edge. End-of-record handling lands one edge later, because devEor is first latched into a flag. The bench drives stimulus 1 ns after each rising edge. A behavioural model advances on the same edge, and every output is compared against it at the falling edge. Directed spot checks are taken 1 ns after the edge that samples the request, with the end-of-record checks moved one clock later.

// File: rtl/chan_out_pkg.sv
package chan_out_pkg;

  typedef enum logic [1:0] {
    CW_6     = 2'd0,
    CW_12    = 2'd1,
    CW_FULL  = 2'd2,
    CW_FULL2 = 2'd3
  } charWidth_e;

  // function code bits: [2] extended, [1] signal, [0] proceed
  localparam logic [2:0] FN_COMP = 3'b000;
  localparam logic [2:0] FN_IORD = 3'b100;
  localparam logic [2:0] FN_IORP = 3'b101;
  localparam logic [2:0] FN_IOSD = 3'b110;
  localparam logic [2:0] FN_IOSP = 3'b111;

  typedef struct packed {
    logic connect;
    logic ilcLoad;
    logic bufLoad;
    logic take;
    logic fetch;
  } ctlStrb_t;

endpackage

// File: rtl/chan_out_dp.sv
module chan_out_dp
  import chan_out_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 14,
  parameter int WC_W   = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [1:0]        cfgWidth,
  input  logic [1:0]        cfgCpw,
  input  logic [ADDR_W-1:0] ilcAddr,
  input  logic [WC_W-1:0]   ilcCount,
  input  logic [WORD_W-1:0] bufData,
  input  logic [WORD_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              bufEmpty,
  output logic              lastChar,
  output logic              wcAfterZero,
  output logic              charValid,
  output logic [WORD_W-1:0] charData
);

  localparam int C6  = WORD_W / 4;
  localparam int C12 = WORD_W / 2;

  charWidth_e          widthQ;
  logic [1:0]          cpwQ;
  logic [2:0]          cntQ;
  logic [WORD_W-1:0]   warQ;
  logic [ADDR_W-1:0]   addrQ;
  logic [WC_W-1:0]     wcQ;

  logic [WORD_W-1:0]   wordIn;
  logic [2:0]          cntIn;
  logic [2:0]          cntFull;
  logic [WC_W-1:0]     wcAfter;
  logic [WORD_W-1:0]   charNext;
  logic [WORD_W-1:0]   wordShifted;
  logic [1:0]          cpwSel;

  assign cntFull     = {1'b0, cpwQ} + 3'd1;
  assign wordIn      = strb.fetch ? memData : warQ;
  assign cntIn       = strb.fetch ? cntFull : cntQ;
  assign wcAfter     = strb.fetch ? wcQ - 1'b1 : wcQ;
  assign bufEmpty    = (cntQ == 3'd0);
  assign lastChar    = (cntIn == 3'd1);
  assign wcAfterZero = (wcAfter == '0);
  assign memAddr     = addrQ;

  always_comb begin
    unique case (widthQ)
      CW_6: begin
        charNext    = WORD_W'(wordIn[WORD_W-1 -: C6]);
        wordShifted = wordIn << C6;
      end
      CW_12: begin
        charNext    = WORD_W'(wordIn[WORD_W-1 -: C12]);
        wordShifted = wordIn << C12;
      end
      default: begin
        charNext    = wordIn;
        wordShifted = '0;
      end
    endcase
  end

  always_comb begin
    unique case (charWidth_e'(cfgWidth))
      CW_6:    cpwSel = cfgCpw;
      CW_12:   cpwSel = {1'b0, cfgCpw[0]};
      default: cpwSel = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      widthQ    <= CW_6;
      cpwQ      <= '0;
      cntQ      <= '0;
      warQ      <= '0;
      addrQ     <= '0;
      wcQ       <= '0;
      charValid <= 1'b0;
      charData  <= '0;
    end else begin
      charValid <= strb.take;
      if (strb.connect) begin
        widthQ <= charWidth_e'(cfgWidth);
        cpwQ   <= cpwSel;
        cntQ   <= '0;
        warQ   <= '0;
        addrQ  <= '0;
        wcQ    <= '0;
      end else begin
        if (strb.take) begin
          charData <= charNext;
          warQ     <= wordShifted;
          cntQ     <= cntIn - 3'd1;
          if (strb.fetch) begin
            addrQ <= addrQ + 1'b1;
            wcQ   <= wcAfter;
          end
        end
        if (strb.ilcLoad) begin
          addrQ <= ilcAddr;
          wcQ   <= ilcCount;
        end
        if (strb.bufLoad) begin
          warQ <= bufData;
          cntQ <= cntFull;
        end
      end
    end
  end

  // R3
  fetchCount_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetch && !strb.ilcLoad && !strb.connect |=> wcQ == WC_W'($past(wcQ) - 1'b1));

  // R10
  loadFill_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.bufLoad |=> !bufEmpty);

endmodule

// File: rtl/chan_out_ctl.sv
module chan_out_ctl
  import chan_out_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       intEnable,
  input  logic       connStart,
  input  logic       connIlc,
  input  logic [2:0] connFunc,
  input  logic       connZcEn,
  input  logic       connErEn,
  input  logic       ilcLoad,
  input  logic       bufWrite,
  input  logic       termCmd,
  input  logic       devReq,
  input  logic       devAsync,
  input  logic       devErr,
  input  logic       devEor,
  input  logic       bufEmpty,
  input  logic       lastChar,
  input  logic       wcAfterZero,
  output ctlStrb_t   strb,
  output logic       memRd,
  output logic       connected,
  output logic       errFlag,
  output logic       interRec,
  output logic       wreor,
  output logic       asyncGrant,
  output logic       irqEow,
  output logic       irqZwc,
  output logic       irqEot,
  output logic       irqEor
);

  logic       connQ, ilceQ, topQ, wakeQ, eorQ, errQ, irecQ, zcQ, erQ;
  logic [2:0] funcQ;
  logic       connN, ilceN, topN, wakeN, eorN, errN, irecN, zcN, erN;
  logic [2:0] funcN;
  logic       wreorN, grantN, eowN, zwcN, eotN, eorIrqN;
  logic       busy;

  assign busy = !bufEmpty || ilceQ;

  always_comb begin
    connN = connQ;  ilceN = ilceQ;  topN = topQ;  wakeN = wakeQ;
    eorN  = eorQ;   errN  = errQ;   irecN = irecQ;
    funcN = funcQ;  zcN   = zcQ;    erN   = erQ;
    wreorN = 1'b0; grantN = 1'b0; eowN = 1'b0;
    zwcN = 1'b0; eotN = 1'b0; eorIrqN = 1'b0;
    strb = '0;

    if (connStart) begin
      connN = 1'b1; ilceN = 1'b0; topN = 1'b0; wakeN = 1'b0;
      eorN  = 1'b0; errN  = 1'b0; irecN = 1'b0;
      funcN = connFunc; zcN = connZcEn; erN = connErEn;
      strb.connect = 1'b1;
      eowN = !connIlc && intEnable;
    end else if (eorQ) begin
      eorN  = 1'b0;
      ilceN = 1'b0;
      eotN    = !funcQ[2] && intEnable;
      eorIrqN = funcQ[2] && erQ;
      if (funcQ[2] && funcQ[0]) irecN = 1'b1;
      else                      connN = 1'b0;
    end else if (connQ) begin
      if (ilcLoad) begin
        ilceN = 1'b1;
        strb.ilcLoad = 1'b1;
      end
      if (bufWrite && bufEmpty) begin
        strb.bufLoad = 1'b1;
        if (wakeQ) begin
          grantN = 1'b1;
          wakeN  = 1'b0;
        end
      end
      if (termCmd) begin
        if (busy) topN   = 1'b1;
        else      wreorN = 1'b1;
      end
      if (devAsync) begin
        if (busy) grantN = 1'b1;
        else      wakeN  = 1'b1;
      end
      if (devReq) begin
        if (bufEmpty && !ilceQ) begin
          errN = 1'b1;
        end else begin
          strb.take  = 1'b1;
          strb.fetch = bufEmpty;
          if (lastChar) begin
            if (ilceQ) begin
              if (wcAfterZero) begin
                ilceN = 1'b0;
                if (!funcQ[2]) begin
                  eotN  = intEnable;
                  connN = 1'b0;
                end else begin
                  zwcN = zcQ;
                  if (funcQ[1] && !funcQ[0]) begin
                    eorIrqN = erQ;
                    connN   = 1'b0;
                  end else if (!funcQ[1] || topQ) begin
                    wreorN = 1'b1;
                  end
                  topN = 1'b0;
                end
              end
            end else if (topQ) begin
              topN   = 1'b0;
              wreorN = 1'b1;
            end else begin
              eowN = intEnable;
            end
          end
        end
      end
      if (devErr) errN = 1'b1;
    end

    if (devEor && !connStart && connQ) eorN = 1'b1;
  end

  assign memRd = strb.fetch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      connQ <= 1'b0; ilceQ <= 1'b0; topQ <= 1'b0; wakeQ <= 1'b0;
      eorQ  <= 1'b0; errQ  <= 1'b0; irecQ <= 1'b0;
      funcQ <= FN_COMP; zcQ <= 1'b0; erQ <= 1'b0;
      wreor <= 1'b0; asyncGrant <= 1'b0; irqEow <= 1'b0;
      irqZwc <= 1'b0; irqEot <= 1'b0; irqEor <= 1'b0;
    end else begin
      connQ <= connN; ilceQ <= ilceN; topQ <= topN; wakeQ <= wakeN;
      eorQ  <= eorN;  errQ  <= errN;  irecQ <= irecN;
      funcQ <= funcN; zcQ <= zcN; erQ <= erN;
      wreor <= wreorN; asyncGrant <= grantN; irqEow <= eowN;
      irqZwc <= zwcN; irqEot <= eotN; irqEor <= eorIrqN;
    end
  end

  assign connected = connQ;
  assign errFlag   = errQ;
  assign interRec  = irecQ;

  // R13
  errSticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errQ && !connStart |=> errQ);

  // R9
  wreorConn_chk: assert property (@(posedge clk) disable iff (!rstN)
    wreor |-> $past(connQ));

  // R2
  connRise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(connQ) |-> $past(connStart));

  // R11
  grantCause_chk: assert property (@(posedge clk) disable iff (!rstN)
    asyncGrant |-> $past(devAsync || bufWrite));

endmodule

// File: rtl/chan_out_disasm.sv
module chan_out_disasm
  import chan_out_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 14,
  parameter int WC_W   = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intEnable,
  input  logic              connStart,
  input  logic              connIlc,
  input  logic [1:0]        connWidth,
  input  logic [1:0]        connCpw,
  input  logic [2:0]        connFunc,
  input  logic              connZcEn,
  input  logic              connErEn,
  input  logic              ilcLoad,
  input  logic [ADDR_W-1:0] ilcAddr,
  input  logic [WC_W-1:0]   ilcCount,
  input  logic              bufWrite,
  input  logic [WORD_W-1:0] bufData,
  input  logic              termCmd,
  input  logic              devReq,
  input  logic              devAsync,
  input  logic              devErr,
  input  logic              devEor,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [WORD_W-1:0] memData,
  output logic              charValid,
  output logic [WORD_W-1:0] charData,
  output logic              wreor,
  output logic              asyncGrant,
  output logic              irqEow,
  output logic              irqZwc,
  output logic              irqEot,
  output logic              irqEor,
  output logic              connected,
  output logic              errFlag,
  output logic              interRec
);

  ctlStrb_t strb;
  logic     bufEmpty, lastChar, wcAfterZero;

  chan_out_ctl u_ctl (
    .clk(clk), .rstN(rstN), .intEnable(intEnable),
    .connStart(connStart), .connIlc(connIlc), .connFunc(connFunc),
    .connZcEn(connZcEn), .connErEn(connErEn), .ilcLoad(ilcLoad),
    .bufWrite(bufWrite), .termCmd(termCmd), .devReq(devReq),
    .devAsync(devAsync), .devErr(devErr), .devEor(devEor),
    .bufEmpty(bufEmpty), .lastChar(lastChar), .wcAfterZero(wcAfterZero),
    .strb(strb), .memRd(memRd), .connected(connected), .errFlag(errFlag),
    .interRec(interRec), .wreor(wreor), .asyncGrant(asyncGrant),
    .irqEow(irqEow), .irqZwc(irqZwc), .irqEot(irqEot), .irqEor(irqEor)
  );

  chan_out_dp #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .WC_W(WC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgWidth(connWidth), .cfgCpw(connCpw),
    .ilcAddr(ilcAddr), .ilcCount(ilcCount), .bufData(bufData),
    .memData(memData), .memAddr(memAddr),
    .bufEmpty(bufEmpty), .lastChar(lastChar), .wcAfterZero(wcAfterZero),
    .charValid(charValid), .charData(charData)
  );

endmodule

// File: tb/chan_out_disasm_test.sv
`timescale 1ns/1ps
module chan_out_disasm_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intEnable = 1'b0, connStart = 1'b0, connIlc = 1'b0;
  logic [1:0] connWidth = '0, connCpw = '0;
  logic [2:0] connFunc = '0;
  logic connZcEn = 1'b0, connErEn = 1'b0, ilcLoad = 1'b0;
  logic [13:0] ilcAddr = '0;
  logic [14:0] ilcCount = '0;
  logic bufWrite = 1'b0;
  logic [23:0] bufData = '0;
  logic termCmd = 1'b0, devReq = 1'b0, devAsync = 1'b0, devErr = 1'b0, devEor = 1'b0;
  logic memRd;
  logic [13:0] memAddr;
  logic [23:0] memData, charData;
  logic charValid, wreor, asyncGrant, irqEow, irqZwc, irqEot, irqEor;
  logic connected, errFlag, interRec;

  int checks = 0, fails = 0, cycles = 0;
  string curReq = "R1";
  bit started = 0;

  always #4 clk = ~clk;

  function automatic logic [23:0] memWord(input logic [13:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'h11, ~a[7:0]};
  endfunction

  assign memData = memWord(memAddr);

  chan_out_disasm uut (
    .clk(clk), .rstN(rstN), .intEnable(intEnable), .connStart(connStart),
    .connIlc(connIlc), .connWidth(connWidth), .connCpw(connCpw),
    .connFunc(connFunc), .connZcEn(connZcEn), .connErEn(connErEn),
    .ilcLoad(ilcLoad), .ilcAddr(ilcAddr), .ilcCount(ilcCount),
    .bufWrite(bufWrite), .bufData(bufData), .termCmd(termCmd),
    .devReq(devReq), .devAsync(devAsync), .devErr(devErr), .devEor(devEor),
    .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .charValid(charValid), .charData(charData), .wreor(wreor),
    .asyncGrant(asyncGrant), .irqEow(irqEow), .irqZwc(irqZwc),
    .irqEot(irqEot), .irqEor(irqEor), .connected(connected),
    .errFlag(errFlag), .interRec(interRec)
  );

  // ---------------- behavioural reference model ----------------
  bit mConn, mIlce, mTop, mWake, mEor, mErr, mIrec, mZc, mEr;
  int mFunc, mWidth, mCpw, mCnt, mWar, mAddr, mWc;
  bit eCv, eWr, eGr, eEow, eZwc, eEot, eEor;
  int eCd;

  always @(posedge clk) begin
    bit wasConn;
    int bits;
    wasConn = mConn;
    eCv = 0; eWr = 0; eGr = 0; eEow = 0; eZwc = 0; eEot = 0; eEor = 0;
    if (!rstN) begin
      mConn = 0; mIlce = 0; mTop = 0; mWake = 0; mEor = 0; mErr = 0; mIrec = 0;
      mZc = 0; mEr = 0; mFunc = 0; mWidth = 0; mCpw = 0; mCnt = 0; mWar = 0;
      mAddr = 0; mWc = 0; eCd = 0;
    end else begin
      if (connStart) begin
        mConn = 1; mIlce = 0; mTop = 0; mWake = 0; mEor = 0; mErr = 0; mIrec = 0;
        mFunc = connFunc; mZc = connZcEn; mEr = connErEn; mWidth = connWidth;
        mCpw = (connWidth == 0) ? connCpw : (connWidth == 1) ? (connCpw & 1) : 0;
        mWar = 0; mCnt = 0; mAddr = 0; mWc = 0;
        eEow = !connIlc && intEnable;
      end else if (mEor) begin
        mEor = 0; mIlce = 0;
        eEot = (mFunc < 4) && intEnable;
        eEor = (mFunc >= 4) && mEr;
        if (mFunc == 5 || mFunc == 7) mIrec = 1; else mConn = 0;
      end else if (mConn) begin
        if (ilcLoad) begin mIlce = 1; mAddr = ilcAddr; mWc = ilcCount; end
        if (bufWrite && mCnt == 0) begin
          mWar = bufData; mCnt = mCpw + 1;
          if (mWake) begin eGr = 1; mWake = 0; end
        end
        if (termCmd) begin
          if (mCnt != 0 || mIlce) mTop = 1; else eWr = 1;
        end
        if (devAsync) begin
          if (mCnt != 0 || mIlce) eGr = 1; else mWake = 1;
        end
        if (devReq) begin
          if (mCnt == 0 && !mIlce) mErr = 1;
          else begin
            if (mCnt == 0) begin
              mWar = memWord(mAddr[13:0]); mAddr = (mAddr + 1) % 16384;
              mWc = (mWc - 1) & 32'h7FFF; mCnt = mCpw + 1;
            end
            bits = (mWidth == 0) ? 6 : (mWidth == 1) ? 12 : 24;
            eCd = (mWar >> (24 - bits)) & ((1 << bits) - 1);
            mWar = (bits == 24) ? 0 : ((mWar << bits) & 32'hFFFFFF);
            mCnt = mCnt - 1; eCv = 1;
            if (mCnt == 0) begin
              if (mIlce) begin
                if (mWc == 0) begin
                  mIlce = 0;
                  if (mFunc < 4) begin eEot = intEnable; mConn = 0; end
                  else begin
                    eZwc = mZc;
                    if (mFunc == 6) begin eEor = mEr; mConn = 0; end
                    else if (mFunc == 4 || mFunc == 5 || mTop) eWr = 1;
                    mTop = 0;
                  end
                end
              end else if (mTop) begin mTop = 0; eWr = 1; end
              else eEow = intEnable;
            end
          end
        end
        if (devErr) mErr = 1;
      end
      if (devEor && !connStart && wasConn) mEor = 1;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      logic [9:0] act, exp;
      act = {charValid, wreor, asyncGrant, irqEow, irqZwc, irqEot, irqEor, connected, errFlag, interRec};
      exp = {eCv, eWr, eGr, eEow, eZwc, eEot, eEor, mConn, mErr, mIrec};
      checks++;
      if (act !== exp || (eCv && charData !== eCd[23:0])) begin
        fails++;
        $display("FAIL %s model: flags %b exp %b, char %h exp %h", curReq, act, exp, charData, eCd[23:0]);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s spot: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic connectCh(input bit ilc, input logic [1:0] w, input logic [1:0] c,
                           input logic [2:0] f, input bit zc, input bit er);
    connStart = 1; connIlc = ilc; connWidth = w; connCpw = c; connFunc = f;
    connZcEn = zc; connErEn = er;
    tick(); connStart = 0;
  endtask

  task automatic loadIlc(input logic [13:0] a, input logic [14:0] n);
    ilcLoad = 1; ilcAddr = a; ilcCount = n; tick(); ilcLoad = 0;
  endtask

  task automatic writeBuf(input logic [23:0] d);
    bufWrite = 1; bufData = d; tick(); bufWrite = 0;
  endtask

  task automatic request();
    devReq = 1; tick(); devReq = 0;
  endtask

  task automatic reqChar(input string req, input int exp);
    request();
    chk(charValid && charData == exp[23:0], req, charData, exp);
  endtask

  task automatic pulseEor();
    devEor = 1; tick(); devEor = 0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected done", cycles);
      finishRun();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [23:0] w;
    idle(3);
    rstN = 1; started = 1;
    curReq = "R1"; idle(2);
    chk(!connected && !errFlag && !interRec && !charValid && !wreor, "R1", connected, 0);

    // R2 program connect raises EOW; interlace connect does not
    curReq = "R2"; intEnable = 1;
    connectCh(0, 2'd0, 2'd3, 3'b000, 0, 0);
    chk(irqEow && connected, "R2", irqEow, 1);
    connectCh(1, 2'd0, 2'd3, 3'b000, 0, 0);
    chk(!irqEow, "R2", irqEow, 0);
    connectCh(0, 2'd0, 2'd3, 3'b000, 0, 0);
    idle(1);

    // R10 buffer load, second load ignored; R4 6-bit ordering; R8 EOW on empty
    curReq = "R10";
    writeBuf(24'hABCDEF);
    writeBuf(24'h123456);
    curReq = "R4";
    reqChar("R4", 'h2A);
    reqChar("R10", 'h3C);
    reqChar("R4", 'h37);
    curReq = "R8";
    reqChar("R8", 'h2F);
    chk(irqEow && !wreor, "R8", irqEow, 1);

    // R9 idle terminate -> immediate wreor; R12 compatible EOR handling
    curReq = "R9";
    termCmd = 1; tick(); termCmd = 0;
    chk(wreor, "R9", wreor, 1);
    curReq = "R12";
    pulseEor(); tick();
    chk(irqEot && !connected, "R12", irqEot, 1);
    idle(1);

    // R9 deferred terminate, released by last character (R8)
    curReq = "R9";
    connectCh(0, 2'd0, 2'd3, 3'b000, 0, 0);
    writeBuf(24'hFEDCBA);
    termCmd = 1; tick(); termCmd = 0;
    chk(!wreor, "R9", wreor, 0);
    request(); request(); request();
    curReq = "R8";
    request();
    chk(wreor && !irqEow, "R8", wreor, 1);
    idle(1);

    // R4 12-bit and full-word widths
    curReq = "R4";
    connectCh(0, 2'd1, 2'd3, 3'b000, 0, 0);
    writeBuf(24'hABCDEF);
    reqChar("R4", 'hABC);
    reqChar("R4", 'hDEF);
    connectCh(0, 2'd2, 2'd3, 3'b000, 0, 0);
    writeBuf(24'h13579B);
    reqChar("R4", 'h13579B);
    chk(irqEow, "R4", irqEow, 1);

    // R5 rate error; R13 sticky and device error
    curReq = "R5";
    request();
    chk(!charValid && errFlag, "R5", errFlag, 1);
    curReq = "R13";
    idle(3);
    chk(errFlag, "R13", errFlag, 1);
    connectCh(0, 2'd0, 2'd0, 3'b000, 0, 0);
    chk(!errFlag, "R13", errFlag, 0);
    devErr = 1; tick(); devErr = 0;
    chk(errFlag, "R13", errFlag, 1);

    // R5 request during EOR handling: dropped, no error
    curReq = "R5";
    connectCh(0, 2'd0, 2'd0, 3'b000, 0, 0);
    pulseEor();
    request();
    chk(!charValid && !errFlag && !connected, "R5", errFlag, 0);

    // R3 / R6 compatible interlace, two words, 6-bit two chars per word
    curReq = "R3";
    connectCh(1, 2'd0, 2'd1, 3'b000, 0, 0);
    loadIlc(14'd5, 15'd2);
    w = memWord(14'd5);
    reqChar("R3", (w >> 18) & 63);
    reqChar("R3", (w >> 12) & 63);
    w = memWord(14'd6);
    reqChar("R3", (w >> 18) & 63);
    curReq = "R6";
    reqChar("R6", (w >> 12) & 63);
    chk(irqEot && !connected, "R6", irqEot, 1);
    idle(1);

    // R7 IOSD: ZWC + EOR + disconnect
    curReq = "R7";
    connectCh(1, 2'd2, 2'd0, 3'b110, 1, 1);
    loadIlc(14'd9, 15'd1);
    reqChar("R7", memWord(14'd9));
    chk(irqZwc && irqEor && !connected && !wreor, "R7", {irqZwc, irqEor, connected}, 3'b110);
    idle(1);

    // R7 IORD: wreor, then R12 extended EOR disconnects
    connectCh(1, 2'd2, 2'd0, 3'b100, 0, 1);
    loadIlc(14'd20, 15'd1);
    reqChar("R7", memWord(14'd20));
    chk(wreor && !irqZwc, "R7", wreor, 1);
    curReq = "R12";
    pulseEor(); tick();
    chk(irqEor && !connected && !interRec, "R12", irqEor, 1);
    idle(1);

    // R12 IORP: inter-record, stays connected
    connectCh(1, 2'd2, 2'd0, 3'b101, 1, 1);
    loadIlc(14'd30, 15'd1);
    request();
    chk(wreor && irqZwc, "R7", wreor, 1);
    pulseEor(); tick();
    chk(irqEor && connected && interRec, "R12", interRec, 1);
    idle(1);

    // R7 IOSP without / with pending terminate
    curReq = "R7";
    connectCh(1, 2'd2, 2'd0, 3'b111, 0, 0);
    loadIlc(14'd40, 15'd1);
    request();
    chk(!wreor && connected, "R7", wreor, 0);
    connectCh(1, 2'd2, 2'd0, 3'b111, 0, 0);
    loadIlc(14'd41, 15'd1);
    curReq = "R9";
    termCmd = 1; tick(); termCmd = 0;
    chk(!wreor, "R9", wreor, 0);
    curReq = "R7";
    request();
    chk(wreor, "R7", wreor, 1);
    idle(1);

    // R11 async wake-up and grant
    curReq = "R11";
    connectCh(0, 2'd0, 2'd0, 3'b000, 0, 0);
    devAsync = 1; tick(); devAsync = 0;
    chk(!asyncGrant, "R11", asyncGrant, 0);
    writeBuf(24'h0F0F0F);
    chk(asyncGrant, "R11", asyncGrant, 1);
    devAsync = 1; tick(); devAsync = 0;
    chk(asyncGrant, "R11", asyncGrant, 1);
    writeBuf(24'h111111);
    chk(!asyncGrant, "R11", asyncGrant, 0);
    idle(2);

    started = 0;
    finishRun();
  end

endmodule